// File: doc/BRIEF.md
# Write-Triggered Interrupt Request Decoder

This block lets bus peripherals raise interrupts by performing a memory write instead of driving a dedicated wire. It monitors a simple write interface and positively decodes writes that target a single fixed assertion-register address. A write is decoded only while a feature-enable bit is set and the byte enables cover the lowest data byte. The low bits of the written data select an interrupt number, and a legal, edge-configured number sets the matching bit in a pending-request register.

Pending requests go to a downstream message sender over a valid/ready handshake, lowest number first. Each pending bit clears in the cycle its handshake completes. A configuration port selects the trigger mode of each interrupt input and sets the feature-enable bit. A write is dropped when it selects a reserved number, a number outside the supported range, or an input configured as level-triggered. Repeated writes for a request that is already pending merge into one message.

Top module: `write_irq_decoder`

## Requirements
- R1: A write is claimed (`wrClaim` high in the same cycle) only when `wrValid` is high and `wrAddr` equals 32'hFEC0_0020, with the enable and byte-enable conditions met. A write to any other address changes no pending bit.
- R2: While the feature-enable bit is 0, no write is claimed and no pending bit is set. The bit is written through `cfgFeatWe`/`cfgFeatVal` and is 0 after reset.
- R3: A write is claimed only when `wrByteEn[0]` is 1. A write with `wrByteEn[0]` at 0 has no effect.
- R4: The interrupt number is the binary value of `wrData[4:0]`, and `wrData[31:5]` is ignored. A claimed, legal write to an edge-configured input sets pending bit `irqPending[n]` one clock later.
- R5: A number of 24 or above sets no pending bit.
- R6: Numbers 0, 2, 8 and 13 are reserved, and writes selecting them set no pending bit.
- R7: Each of the 24 inputs has a trigger-mode bit (0 = edge, 1 = level). It is written through `cfgTrigWe`/`cfgTrigIdx`/`cfgTrigLevel` and resets to 1 (level). A write to a level-configured input sets no pending bit.
- R8: `msgValid` is high whenever any bit is pending, and `msgVector` carries the lowest-numbered pending bit.
- R9: When `msgValid` and `msgReady` are both high at a clock edge, the offered bit clears at that edge. No other bit changes because of the handshake.
- R10: A write to an already pending bit merges into it, so only one message goes out. A write that sets the bit being cleared in the same cycle leaves it set.
- R11: After reset, `irqPending` is all zero and `msgValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write cycle present on the bus |
| wrAddr | input | 32 | Write address |
| wrData | input | 32 | Write data; bits 4:0 select the interrupt |
| wrByteEn | input | 4 | Byte enables of the write |
| wrClaim | output | 1 | The current write is positively decoded |
| cfgFeatWe | input | 1 | Write strobe for the feature-enable bit |
| cfgFeatVal | input | 1 | New feature-enable value |
| cfgTrigWe | input | 1 | Write strobe for a trigger-mode bit |
| cfgTrigIdx | input | 5 | Input whose trigger mode is written |
| cfgTrigLevel | input | 1 | New trigger mode (1 = level) |
| msgValid | output | 1 | A pending request is offered |
| msgVector | output | 5 | Number of the offered request |
| msgReady | input | 1 | The message sender accepts the offer |
| irqPending | output | 24 | Interrupt request register |

## Verification
The assertions assume that the bus inputs are free of X while reset is released. They also assume that `cfgTrigIdx` stays below 24 whenever `cfgTrigWe` is high. The stimulus keeps to both rules: it drives every input to a defined value from time zero and draws configuration indices only from 0 to 23. Write data, addresses, byte enables and `msgReady` are otherwise unconstrained. Random addresses, reserved and out-of-range numbers, and writes that coincide with a handshake on the same bit are all in the generated mix.

// File: rtl/wirq_pkg.sv
package wirq_pkg;
  localparam int VEC_W = 5;

  typedef struct packed {
    logic             setEn;
    logic [VEC_W-1:0] setIdx;
    logic             clrEn;
    logic [VEC_W-1:0] clrIdx;
  } irqStrobe_t;
endpackage

// File: rtl/wirq_datapath.sv
module wirq_datapath
  import wirq_pkg::*;
#(
  parameter int NUM_IRQ = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic               cfgFeatWe,
  input  logic               cfgFeatVal,
  input  logic               cfgTrigWe,
  input  logic [VEC_W-1:0]   cfgTrigIdx,
  input  logic               cfgTrigLevel,
  output logic [NUM_IRQ-1:0] irr,
  output logic [NUM_IRQ-1:0] trigLevel,
  output logic               featEn,
  output logic               pendValid,
  output logic [VEC_W-1:0]   pendIdx
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) featEn <= 1'b0;
    else if (cfgFeatWe) featEn <= cfgFeatVal;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    // set has priority over clear so a coincident write survives (R10)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irr[g] <= 1'b0;
      else if (strobe.setEn && strobe.setIdx == VEC_W'(g)) irr[g] <= 1'b1;
      else if (strobe.clrEn && strobe.clrIdx == VEC_W'(g)) irr[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) trigLevel[g] <= 1'b1;
      else if (cfgTrigWe && cfgTrigIdx == VEC_W'(g)) trigLevel[g] <= cfgTrigLevel;
    end

    p_level_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irr[g]) |-> $past(!trigLevel[g]));
  end

  always_comb begin
    pendIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irr[i]) pendIdx = VEC_W'(i);
    end
  end
  assign pendValid = |irr;

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !featEn |=> ((irr & ~$past(irr)) == '0));

  p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((irr & ((NUM_IRQ'(1) << pendIdx) - NUM_IRQ'(1))) == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrEn && !(strobe.setEn && strobe.setIdx == strobe.clrIdx))
      |=> !irr[$past(strobe.clrIdx)]);

  p_merge_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> irr[$past(strobe.setIdx)]);

endmodule

// File: rtl/wirq_ctrl.sv
module wirq_ctrl
  import wirq_pkg::*;
#(
  parameter int               NUM_IRQ     = 24,
  parameter logic [31:0]      ASSERT_ADDR = 32'hFEC0_0020,
  parameter logic [NUM_IRQ-1:0] RSVD_MASK = 24'h00_2105
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [31:0]        wrAddr,
  input  logic [31:0]        wrData,
  input  logic [3:0]         wrByteEn,
  input  logic               featEn,
  input  logic [NUM_IRQ-1:0] trigLevel,
  input  logic               pendValid,
  input  logic [VEC_W-1:0]   pendIdx,
  input  logic               msgReady,
  output logic               wrClaim,
  output irqStrobe_t         strobe
);

  localparam int SPACE = 2 ** VEC_W;
  localparam int PAD   = SPACE - NUM_IRQ;
  // numbers beyond the supported range behave as reserved (R5)
  localparam logic [SPACE-1:0] BLOCK_EXT = {{PAD{1'b1}}, RSVD_MASK};

  logic [VEC_W-1:0] vec;
  logic [SPACE-1:0] levelExt;
  logic             legal;

  assign wrClaim  = wrValid && featEn && wrByteEn[0] && (wrAddr == ASSERT_ADDR);
  assign vec      = wrData[VEC_W-1:0];
  assign levelExt = {{PAD{1'b1}}, trigLevel};
  assign legal    = !BLOCK_EXT[vec] && !levelExt[vec];

  always_comb begin
    strobe        = '0;
    strobe.setEn  = wrClaim && legal;
    strobe.setIdx = vec;
    strobe.clrEn  = pendValid && msgReady;
    strobe.clrIdx = pendIdx;
  end

  p_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |-> (strobe.setIdx < VEC_W'(NUM_IRQ)));

  p_claim_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrClaim |-> featEn);

endmodule

// File: rtl/write_irq_decoder.sv
module write_irq_decoder
  import wirq_pkg::*;
#(
  parameter int                 NUM_IRQ     = 24,
  parameter logic [31:0]        ASSERT_ADDR = 32'hFEC0_0020,
  parameter logic [NUM_IRQ-1:0] RSVD_MASK   = 24'h00_2105
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [31:0]        wrAddr,
  input  logic [31:0]        wrData,
  input  logic [3:0]         wrByteEn,
  output logic               wrClaim,
  input  logic               cfgFeatWe,
  input  logic               cfgFeatVal,
  input  logic               cfgTrigWe,
  input  logic [4:0]         cfgTrigIdx,
  input  logic               cfgTrigLevel,
  output logic               msgValid,
  output logic [4:0]         msgVector,
  input  logic               msgReady,
  output logic [NUM_IRQ-1:0] irqPending
);

  irqStrobe_t         strobe;
  logic [NUM_IRQ-1:0] trigLevel;
  logic               featEn;

  wirq_ctrl #(
    .NUM_IRQ(NUM_IRQ), .ASSERT_ADDR(ASSERT_ADDR), .RSVD_MASK(RSVD_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrByteEn(wrByteEn),
    .featEn(featEn), .trigLevel(trigLevel),
    .pendValid(msgValid), .pendIdx(msgVector), .msgReady(msgReady),
    .wrClaim(wrClaim), .strobe(strobe)
  );

  wirq_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgFeatWe(cfgFeatWe), .cfgFeatVal(cfgFeatVal),
    .cfgTrigWe(cfgTrigWe), .cfgTrigIdx(cfgTrigIdx), .cfgTrigLevel(cfgTrigLevel),
    .irr(irqPending), .trigLevel(trigLevel), .featEn(featEn),
    .pendValid(msgValid), .pendIdx(msgVector)
  );

  p_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqPending == '0));

endmodule

// File: tb/write_irq_decoder_tb.sv
module write_irq_decoder_tb;
  localparam logic [31:0] ADDR = 32'hFEC0_0020;

  logic        clk = 0, rstN = 0;
  logic        wrValid = 0;
  logic [31:0] wrAddr = 0, wrData = 0;
  logic [3:0]  wrByteEn = 0;
  logic        cfgFeatWe = 0, cfgFeatVal = 0;
  logic        cfgTrigWe = 0, cfgTrigLevel = 0;
  logic [4:0]  cfgTrigIdx = 0;
  logic        msgReady = 0;
  logic        wrClaim, msgValid;
  logic [4:0]  msgVector;
  logic [23:0] irqPending;

  int checks = 0, errors = 0;

  // behavioural reference state
  bit [23:0] refPend;
  bit [23:0] refLevel;
  bit        refFeat;

  always #4 clk = ~clk;

  write_irq_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrByteEn(wrByteEn), .wrClaim(wrClaim), .cfgFeatWe(cfgFeatWe),
    .cfgFeatVal(cfgFeatVal), .cfgTrigWe(cfgTrigWe), .cfgTrigIdx(cfgTrigIdx),
    .cfgTrigLevel(cfgTrigLevel), .msgValid(msgValid), .msgVector(msgVector),
    .msgReady(msgReady), .irqPending(irqPending)
  );

  function automatic int lowestOf(bit [23:0] v);
    for (int i = 0; i < 24; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit refClaim();
    return wrValid && refFeat && wrByteEn[0] && wrAddr == ADDR;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference update on each edge
  always @(posedge clk) begin
    if (!rstN) begin
      refPend = '0; refLevel = '1; refFeat = 0;
    end else begin
      bit [23:0] nxt;
      int v;
      nxt = refPend;
      if (refPend != 0 && msgReady) nxt[lowestOf(refPend)] = 0;
      v = wrData[4:0];
      if (refClaim() && v < 24 && v != 0 && v != 2 && v != 8 && v != 13 && !refLevel[v])
        nxt[v] = 1;
      if (cfgTrigWe && cfgTrigIdx < 24) refLevel[cfgTrigIdx] = cfgTrigLevel;
      if (cfgFeatWe) refFeat = cfgFeatVal;
      refPend = nxt;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(irqPending == refPend, "R4 R9 irqPending", irqPending, refPend);
      check(msgValid == (refPend != 0), "R8 msgValid", msgValid, refPend != 0);
      if (refPend != 0)
        check(msgVector == lowestOf(refPend), "R8 msgVector", msgVector, lowestOf(refPend));
      check(wrClaim == refClaim(), "R1 wrClaim", wrClaim, refClaim());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic sendWrite(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    wrValid = 1; wrAddr = a; wrData = d; wrByteEn = be;
    tick();
    wrValid = 0;
  endtask

  task automatic setTrig(int idx, bit lvl);
    cfgTrigWe = 1; cfgTrigIdx = 5'(idx); cfgTrigLevel = lvl;
    tick();
    cfgTrigWe = 0;
  endtask

  task automatic setFeat(bit v);
    cfgFeatWe = 1; cfgFeatVal = v;
    tick();
    cfgFeatWe = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R11 reset state
    check(irqPending == 0, "R11 pending after reset", irqPending, 0);
    check(msgValid == 0, "R11 msgValid after reset", msgValid, 0);

    // R2 feature disabled: nothing claimed
    wrValid = 1; wrAddr = ADDR; wrData = 32'd5; wrByteEn = 4'hF; #1;
    check(wrClaim == 0, "R2 claim while disabled", wrClaim, 0);
    tick(); wrValid = 0;
    check(irqPending == 0, "R2 pending while disabled", irqPending, 0);

    setFeat(1);
    // R7 trigger mode resets to level, so a write is blocked
    sendWrite(ADDR, 32'd3, 4'hF);
    check(irqPending == 0, "R7 level after reset blocks", irqPending, 0);

    for (int i = 0; i < 24; i++) setTrig(i, 0);

    // R1 wrong address, then claim on the right one
    sendWrite(ADDR + 4, 32'd5, 4'hF);
    check(irqPending == 0, "R1 other address ignored", irqPending, 0);
    wrValid = 1; wrAddr = ADDR; wrData = 32'd9; wrByteEn = 4'h1; #1;
    check(wrClaim == 1, "R1 claim on match", wrClaim, 1);
    wrValid = 0; tick();

    // R3 byte enable without lane 0
    sendWrite(ADDR, 32'd5, 4'b1110);
    check(irqPending == 0, "R3 byte lane 0 required", irqPending, 0);

    // R4 upper data bits ignored
    sendWrite(ADDR, 32'hFFFF_FFE5, 4'hF);
    check(irqPending == 24'h00_0020, "R4 vector from low bits", irqPending, 24'h00_0020);

    // R5 out of range
    sendWrite(ADDR, 32'd24, 4'hF);
    sendWrite(ADDR, 32'd31, 4'hF);
    check(irqPending == 24'h00_0020, "R5 out of range ignored", irqPending, 24'h00_0020);

    // R6 reserved numbers
    sendWrite(ADDR, 32'd0, 4'hF);
    sendWrite(ADDR, 32'd2, 4'hF);
    sendWrite(ADDR, 32'd8, 4'hF);
    sendWrite(ADDR, 32'd13, 4'hF);
    check(irqPending == 24'h00_0020, "R6 reserved ignored", irqPending, 24'h00_0020);

    // R7 configured level input blocked
    setTrig(9, 1);
    sendWrite(ADDR, 32'd9, 4'hF);
    check(irqPending == 24'h00_0020, "R7 level input blocked", irqPending, 24'h00_0020);

    sendWrite(ADDR, 32'd20, 4'hF);
    sendWrite(ADDR, 32'd7, 4'hF);
    sendWrite(ADDR, 32'd7, 4'hF);
    check(irqPending == 24'h10_00A0, "R10 duplicate merges", irqPending, 24'h10_00A0);
    check(msgVector == 5, "R8 lowest offered", msgVector, 5);

    msgReady = 1; tick(); msgReady = 0;
    check(irqPending == 24'h10_0080, "R9 clear on handshake", irqPending, 24'h10_0080);
    check(msgVector == 7, "R8 next lowest", msgVector, 7);

    msgReady = 1; wrValid = 1; wrAddr = ADDR; wrData = 32'd7; wrByteEn = 4'hF;
    tick(); msgReady = 0; wrValid = 0;
    check(irqPending == 24'h10_0080, "R10 set wins over clear", irqPending, 24'h10_0080);

    msgReady = 1; tick(); tick(); msgReady = 0;
    check(irqPending == 0, "R9 drained", irqPending, 0);

    // mixed random traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      wrValid  = $urandom_range(0, 1);
      wrAddr   = ($urandom_range(0, 3) != 0) ? ADDR : $urandom;
      wrData   = $urandom;
      wrByteEn = 4'($urandom);
      msgReady = ($urandom_range(0, 2) == 0);
      cfgTrigWe = ($urandom_range(0, 15) == 0);
      cfgTrigIdx = 5'($urandom_range(0, 23));
      cfgTrigLevel = ($urandom_range(0, 3) == 0);
      cfgFeatWe = ($urandom_range(0, 63) == 0);
      cfgFeatVal = ($urandom_range(0, 3) != 0);
      tick();
    end
    wrValid = 0; cfgTrigWe = 0; cfgFeatWe = 0; msgReady = 0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule